// File: doc/BRIEF.md
# Dual-Clock Mailbox Register Pair

This block carries single command or control words between two unrelated clock domains, side A and side B. It does not use a queue. It holds two 36-bit registers, one per direction. Mailbox 1 is written from side A and read on side B. Mailbox 2 is written from side B and read on side A. Each mailbox has an active-low "mail present" flag. An accepted write drives the flag low. A read from the opposite side drives it high again. While a flag is low, further writes to that mailbox are refused, so the word cannot change while the reader is looking at it.

Each flag lives as a pair of toggle bits, one owned by each domain, and each toggle is carried across the clock boundary through a two-flop synchronizer. Both sides therefore see both flags in their own clock domain. The writer side sees its own write at once. The reader side sees the write two reader-clock edges later. A clear by the reader reaches the writer the same way. Side A addresses the mailbox with a dedicated select input. Side B addresses it with an all-ones size code, and any other size code routes the data path of a neighbouring queue to the B read bus.

Top module: `mbx_pair`

## Requirements
- R1: While reset is held and right after it, all four flag outputs are high, and both mailbox contents read as zero.
- R2: Mailbox 1 takes a_wdata on a rising clk_a edge only when a_sel, a_en, a_wr and a_mbox are all 1 and a_flag1_n is high. Every other control combination leaves it unchanged.
- R3: Mailbox 2 takes b_wdata on a rising clk_b edge only when b_sel, b_en and b_wr are 1, b_size is 2'b11 and b_flag2_n is high. Size codes 2'b00, 2'b01 and 2'b10 write nothing.
- R4: An accepted write drives the writer-side flag (a_flag1_n or b_flag2_n) low after that same edge. While that flag is low, writes to that mailbox are ignored.
- R5: After an accepted write, the reader-side flag (b_flag1_n or a_flag2_n) is still high after the first reader-clock edge and is low after the second.
- R6: A side-B read (b_sel=1, b_en=1, b_wr=0, b_size=2'b11) with b_flag1_n low drives b_flag1_n high after that clk_b edge. a_flag1_n then stays low for one more clk_a edge and goes high after the second.
- R7: A side-A read (a_sel=1, a_en=1, a_wr=0, a_mbox=1) with a_flag2_n low drives a_flag2_n high after that clk_a edge. b_flag2_n goes high after the second clk_b edge that follows.
- R8: A read leaves mailbox contents unchanged. A read with a_mbox=0 or with b_size other than 2'b11 does not clear any flag.
- R9: b_rdata shows mailbox 1 when b_size is 2'b11 and b_fifo_q otherwise. a_rdata always shows mailbox 2.
- R10: Driving rst_n low forces all flags high and both mailboxes to zero at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Side A clock |
| clk_b | input | 1 | Side B clock |
| rst_n | input | 1 | Asynchronous active-low reset, released per domain synchronously |
| a_sel | input | 1 | Side A access select, active high |
| a_en | input | 1 | Side A access enable, active high |
| a_wr | input | 1 | Side A direction: 1 write, 0 read |
| a_mbox | input | 1 | Side A mailbox select, active high |
| a_wdata | input | 36 | Side A write data for mailbox 1 |
| a_rdata | output | 36 | Mailbox 2 contents seen by side A |
| a_flag1_n | output | 1 | Mailbox 1 flag in clk_a domain, low when mail is present |
| a_flag2_n | output | 1 | Mailbox 2 flag in clk_a domain, low when mail is present |
| b_sel | input | 1 | Side B access select, active high |
| b_en | input | 1 | Side B access enable, active high |
| b_wr | input | 1 | Side B direction: 1 write, 0 read |
| b_size | input | 2 | Side B size code, 2'b11 selects the mailbox |
| b_wdata | input | 36 | Side B write data for mailbox 2 |
| b_fifo_q | input | 36 | Queue output word, routed to b_rdata for other size codes |
| b_rdata | output | 36 | Side B read bus |
| b_flag1_n | output | 1 | Mailbox 1 flag in clk_b domain, low when mail is present |
| b_flag2_n | output | 1 | Mailbox 2 flag in clk_b domain, low when mail is present |

## Verification
On every clock edge, the assertions check that accepted writes are captured and drive the writer-side flag low. They also check that the mailbox contents hold while the flag is low or no write is selected, and that a valid read clears the reader-side flag. Only the bench scenarios can show the two-edge crossing latency in each direction and the full sweep of control and size codes. The same applies to the read-bus routing under each size code, repeated round trips with varied data, and the asynchronous effect of reset mid-operation.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int unsigned MBX_DW     = 36;
  localparam int unsigned MBX_SYNC   = 2;
  localparam int unsigned MBX_NUM    = 2;
  localparam logic [1:0]  SIZE_MBOX  = 2'b11;

  typedef struct packed {
    logic sel;
    logic en;
    logic wr;
    logic tgt;
  } port_ctl_t;

  function automatic logic is_write(input port_ctl_t c);
    return c.sel & c.en & c.wr & c.tgt;
  endfunction

  function automatic logic is_read(input port_ctl_t c);
    return c.sel & c.en & ~c.wr & c.tgt;
  endfunction
endpackage

// File: rtl/mbx_rst_sync.sv
module mbx_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/mbx_sync.sv
module mbx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] stg_q;
  logic [STAGES-1:0] stg_d;

  always_comb begin
    stg_d = {stg_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= stg_d;
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/mbx_channel.sv
module mbx_channel #(
  parameter int unsigned DW     = 36,
  parameter int unsigned STAGES = 2
) (
  input  logic          wclk,
  input  logic          wrst_n,
  input  logic          rclk,
  input  logic          rrst_n,
  input  logic          wr_req,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_req,
  output logic [DW-1:0] mbox_q,
  output logic          w_flag_n,
  output logic          r_flag_n
);
  logic          w_tog_q, w_tog_d;
  logic          r_tog_q, r_tog_d;
  logic [DW-1:0] data_q, data_d;
  logic          data_en;
  logic          r_tog_in_w;
  logic          w_tog_in_r;
  logic          wr_acc;
  logic          rd_acc;

  mbx_sync #(.STAGES(STAGES)) u_sync_r2w (
    .clk   (wclk),
    .rst_n (wrst_n),
    .d     (r_tog_q),
    .q     (r_tog_in_w)
  );

  mbx_sync #(.STAGES(STAGES)) u_sync_w2r (
    .clk   (rclk),
    .rst_n (rrst_n),
    .d     (w_tog_q),
    .q     (w_tog_in_r)
  );

  assign w_flag_n = ~(w_tog_q ^ r_tog_in_w);
  assign r_flag_n = ~(w_tog_in_r ^ r_tog_q);
  assign wr_acc   = wr_req & w_flag_n;
  assign rd_acc   = rd_req & ~r_flag_n;

  always_comb begin
    w_tog_d = w_tog_q;
    data_en = 1'b0;
    data_d  = data_q;
    if (wr_acc) begin
      w_tog_d = ~w_tog_q;
      data_en = 1'b1;
      data_d  = wr_data;
    end
  end

  always_comb begin
    r_tog_d = r_tog_q;
    if (rd_acc) r_tog_d = ~r_tog_q;
  end

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      w_tog_q <= 1'b0;
      data_q  <= '0;
    end else begin
      w_tog_q <= w_tog_d;
      if (data_en) data_q <= data_d;
    end
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) r_tog_q <= 1'b0;
    else         r_tog_q <= r_tog_d;
  end

  assign mbox_q = data_q;
endmodule

// File: rtl/mbx_pair.sv
module mbx_pair
  import mbx_pkg::*;
#(
  parameter int unsigned DW     = MBX_DW,
  parameter int unsigned STAGES = MBX_SYNC
) (
  input  logic          clk_a,
  input  logic          clk_b,
  input  logic          rst_n,
  input  logic          a_sel,
  input  logic          a_en,
  input  logic          a_wr,
  input  logic          a_mbox,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  output logic          a_flag1_n,
  output logic          a_flag2_n,
  input  logic          b_sel,
  input  logic          b_en,
  input  logic          b_wr,
  input  logic [1:0]    b_size,
  input  logic [DW-1:0] b_wdata,
  input  logic [DW-1:0] b_fifo_q,
  output logic [DW-1:0] b_rdata,
  output logic          b_flag1_n,
  output logic          b_flag2_n
);
  localparam int unsigned NCH = MBX_NUM;

  logic          rst_a_n, rst_b_n;
  port_ctl_t     ctl_a, ctl_b;
  logic          a_wr_hit, a_rd_hit, b_wr_hit, b_rd_hit;
  logic          b_mbx_sel;

  logic [NCH-1:0]         ch_wclk, ch_rclk, ch_wrst, ch_rrst;
  logic [NCH-1:0]         ch_wreq, ch_rreq, ch_wflag, ch_rflag;
  logic [NCH-1:0][DW-1:0] ch_wdata, ch_q;

  mbx_rst_sync #(.STAGES(STAGES)) u_rst_a (
    .clk(clk_a), .rst_n(rst_n), .rst_sync_n(rst_a_n)
  );
  mbx_rst_sync #(.STAGES(STAGES)) u_rst_b (
    .clk(clk_b), .rst_n(rst_n), .rst_sync_n(rst_b_n)
  );

  always_comb begin
    b_mbx_sel = (b_size == SIZE_MBOX);
    ctl_a     = '{sel: a_sel, en: a_en, wr: a_wr, tgt: a_mbox};
    ctl_b     = '{sel: b_sel, en: b_en, wr: b_wr, tgt: b_mbx_sel};
    a_wr_hit  = is_write(ctl_a);
    a_rd_hit  = is_read(ctl_a);
    b_wr_hit  = is_write(ctl_b);
    b_rd_hit  = is_read(ctl_b);
  end

  // channel 0 carries A->B (mailbox 1), channel 1 carries B->A (mailbox 2)
  assign ch_wclk  = {clk_b, clk_a};
  assign ch_rclk  = {clk_a, clk_b};
  assign ch_wrst  = {rst_b_n, rst_a_n};
  assign ch_rrst  = {rst_a_n, rst_b_n};
  assign ch_wreq  = {b_wr_hit, a_wr_hit};
  assign ch_rreq  = {a_rd_hit, b_rd_hit};
  assign ch_wdata = {b_wdata, a_wdata};

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    mbx_channel #(.DW(DW), .STAGES(STAGES)) u_ch (
      .wclk     (ch_wclk[i]),
      .wrst_n   (ch_wrst[i]),
      .rclk     (ch_rclk[i]),
      .rrst_n   (ch_rrst[i]),
      .wr_req   (ch_wreq[i]),
      .wr_data  (ch_wdata[i]),
      .rd_req   (ch_rreq[i]),
      .mbox_q   (ch_q[i]),
      .w_flag_n (ch_wflag[i]),
      .r_flag_n (ch_rflag[i])
    );
  end

  assign a_flag1_n = ch_wflag[0];
  assign b_flag1_n = ch_rflag[0];
  assign b_flag2_n = ch_wflag[1];
  assign a_flag2_n = ch_rflag[1];
  assign a_rdata   = ch_q[1];
  assign b_rdata   = b_mbx_sel ? ch_q[0] : b_fifo_q;
endmodule

// File: rtl/mbx_pair_chk.sv
module mbx_pair_chk #(
  parameter int unsigned DW = 36
) (
  input logic          clk_a,
  input logic          clk_b,
  input logic          rst_a_n,
  input logic          rst_b_n,
  input logic          a_wr_hit,
  input logic          a_rd_hit,
  input logic          b_wr_hit,
  input logic          b_rd_hit,
  input logic          a_flag1_n,
  input logic          a_flag2_n,
  input logic          b_flag1_n,
  input logic          b_flag2_n,
  input logic [DW-1:0] mb1,
  input logic [DW-1:0] mb2,
  input logic [DW-1:0] a_wdata,
  input logic [DW-1:0] b_wdata
);
  p_capture_a_r2: assert property (@(posedge clk_a) disable iff (!rst_a_n)
    (a_wr_hit && a_flag1_n) |=> (mb1 == $past(a_wdata)));

  p_capture_b_r3: assert property (@(posedge clk_b) disable iff (!rst_b_n)
    (b_wr_hit && b_flag2_n) |=> (mb2 == $past(b_wdata)));

  p_flag_low_a_r4: assert property (@(posedge clk_a) disable iff (!rst_a_n)
    (a_wr_hit && a_flag1_n) |=> !a_flag1_n);

  p_flag_low_b_r4: assert property (@(posedge clk_b) disable iff (!rst_b_n)
    (b_wr_hit && b_flag2_n) |=> !b_flag2_n);

  p_lock_a_r4: assert property (@(posedge clk_a) disable iff (!rst_a_n)
    !a_flag1_n |=> $stable(mb1));

  p_lock_b_r4: assert property (@(posedge clk_b) disable iff (!rst_b_n)
    !b_flag2_n |=> $stable(mb2));

  p_clear1_r6: assert property (@(posedge clk_b) disable iff (!rst_b_n)
    (b_rd_hit && !b_flag1_n) |=> b_flag1_n);

  p_clear2_r7: assert property (@(posedge clk_a) disable iff (!rst_a_n)
    (a_rd_hit && !a_flag2_n) |=> a_flag2_n);

  p_hold_a_r8: assert property (@(posedge clk_a) disable iff (!rst_a_n)
    !a_wr_hit |=> $stable(mb1));

  p_hold_b_r8: assert property (@(posedge clk_b) disable iff (!rst_b_n)
    !b_wr_hit |=> $stable(mb2));
endmodule

bind mbx_pair mbx_pair_chk #(.DW(DW)) u_chk (
  .clk_a     (clk_a),
  .clk_b     (clk_b),
  .rst_a_n   (rst_a_n),
  .rst_b_n   (rst_b_n),
  .a_wr_hit  (a_wr_hit),
  .a_rd_hit  (a_rd_hit),
  .b_wr_hit  (b_wr_hit),
  .b_rd_hit  (b_rd_hit),
  .a_flag1_n (a_flag1_n),
  .a_flag2_n (a_flag2_n),
  .b_flag1_n (b_flag1_n),
  .b_flag2_n (b_flag2_n),
  .mb1       (ch_q[0]),
  .mb2       (ch_q[1]),
  .a_wdata   (a_wdata),
  .b_wdata   (b_wdata)
);

// File: tb/mbx_pair_tb.sv
`timescale 1ns/100ps
module mbx_pair_tb;
  localparam int DW = 36;

  logic clk_a = 1'b0;
  logic clk_b = 1'b0;
  logic rst_n;
  logic a_sel, a_en, a_wr, a_mbox;
  logic [DW-1:0] a_wdata, a_rdata;
  logic a_flag1_n, a_flag2_n;
  logic b_sel, b_en, b_wr;
  logic [1:0] b_size;
  logic [DW-1:0] b_wdata, b_fifo_q, b_rdata;
  logic b_flag1_n, b_flag2_n;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [DW-1:0] exp1, exp2, got;

  always #2   clk_a = ~clk_a;
  always #3.5 clk_b = ~clk_b;

  mbx_pair u_dut (
    .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n),
    .a_sel(a_sel), .a_en(a_en), .a_wr(a_wr), .a_mbox(a_mbox),
    .a_wdata(a_wdata), .a_rdata(a_rdata),
    .a_flag1_n(a_flag1_n), .a_flag2_n(a_flag2_n),
    .b_sel(b_sel), .b_en(b_en), .b_wr(b_wr), .b_size(b_size),
    .b_wdata(b_wdata), .b_fifo_q(b_fifo_q), .b_rdata(b_rdata),
    .b_flag1_n(b_flag1_n), .b_flag2_n(b_flag2_n)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic a_op(input logic s, input logic e, input logic w, input logic m,
                      input logic [DW-1:0] d);
    @(negedge clk_a);
    a_sel = s; a_en = e; a_wr = w; a_mbox = m; a_wdata = d;
    @(posedge clk_a);
    #0.1;
    a_sel = 1'b0; a_en = 1'b0; a_wr = 1'b0; a_mbox = 1'b0;
  endtask

  task automatic b_op(input logic s, input logic e, input logic w, input logic [1:0] z,
                      input logic [DW-1:0] d);
    @(negedge clk_b);
    b_sel = s; b_en = e; b_wr = w; b_size = z; b_wdata = d;
    @(posedge clk_b);
    #0.1;
    b_sel = 1'b0; b_en = 1'b0; b_wr = 1'b0; b_size = 2'b00;
  endtask

  task automatic peek1(output logic [DW-1:0] v);
    b_size = 2'b11;
    #0.1;
    v = b_rdata;
    b_size = 2'b00;
  endtask

  task automatic wait_a(input int n);
    repeat (n) @(posedge clk_a);
    #0.1;
  endtask

  task automatic wait_b(input int n);
    repeat (n) @(posedge clk_b);
    #0.1;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    rst_n = 1'b0;
    a_sel = 0; a_en = 0; a_wr = 0; a_mbox = 0; a_wdata = '0;
    b_sel = 0; b_en = 0; b_wr = 0; b_size = 2'b00; b_wdata = '0;
    b_fifo_q = 36'hF_0F0F_0F0F;
    exp1 = '0; exp2 = '0;
    #20;
    // R1 state during reset
    chk("R1 a_flag1_n in reset", a_flag1_n, 1);
    chk("R1 b_flag2_n in reset", b_flag2_n, 1);
    @(negedge clk_a); rst_n = 1'b1;
    wait_a(4); wait_b(4);
    chk("R1 a_flag1_n", a_flag1_n, 1);
    chk("R1 a_flag2_n", a_flag2_n, 1);
    chk("R1 b_flag1_n", b_flag1_n, 1);
    chk("R1 b_flag2_n", b_flag2_n, 1);
    chk("R1 a_rdata", a_rdata, '0);
    peek1(got); chk("R1 mailbox1", got, '0);

    // R2 sweep of all non-write side A control codes: nothing changes
    for (int i = 0; i < 15; i++) begin
      a_op(i[3], i[2], i[1], i[0], 36'h1_0000_0000 + 36'(i * 7919));
      peek1(got); chk("R2 no write", got, '0);
      chk("R2 flag stays", a_flag1_n, 1);
    end

    // R2/R4/R5 accepted write and crossing latency
    exp1 = 36'hA_5A5A_1234;
    a_op(1, 1, 1, 1, exp1);
    chk("R4 a_flag1_n low", a_flag1_n, 0);
    wait_b(1); chk("R5 b_flag1_n after 1 edge", b_flag1_n, 1);
    wait_b(1); chk("R5 b_flag1_n after 2 edges", b_flag1_n, 0);
    peek1(got); chk("R2 mailbox1 data", got, exp1);

    // R4 locked write
    a_op(1, 1, 1, 1, 36'h0_DEAD_BEEF);
    peek1(got); chk("R4 locked write ignored", got, exp1);

    // R9/R8 reads with other size codes route the queue and do not clear
    for (int z = 0; z < 3; z++) begin
      b_fifo_q = 36'h3_0000_0011 * 36'(z + 1);
      b_op(1, 1, 0, 2'(z), '0);
      b_size = 2'(z); #0.1;
      chk("R9 queue routed", b_rdata, b_fifo_q);
      b_size = 2'b00;
      chk("R8 no clear on other size", b_flag1_n, 0);
    end

    // R6 mailbox read clears
    b_op(1, 1, 0, 2'b11, '0);
    chk("R6 b_flag1_n high", b_flag1_n, 1);
    peek1(got); chk("R8 contents after read", got, exp1);
    wait_a(1); chk("R6 a_flag1_n after 1 edge", a_flag1_n, 0);
    wait_a(1); chk("R6 a_flag1_n after 2 edges", a_flag1_n, 1);

    // R3 side B size sweep: only 2'b11 writes
    for (int z = 0; z < 3; z++) begin
      b_op(1, 1, 1, 2'(z), 36'h7_7777_0000 + 36'(z));
      chk("R3 no write", a_rdata, '0);
      chk("R3 flag stays", b_flag2_n, 1);
    end
    exp2 = 36'h5_CAFE_0042;
    b_op(1, 1, 1, 2'b11, exp2);
    chk("R4 b_flag2_n low", b_flag2_n, 0);
    chk("R3 mailbox2 data", a_rdata, exp2);
    wait_a(1); chk("R5 a_flag2_n after 1 edge", a_flag2_n, 1);
    wait_a(1); chk("R5 a_flag2_n after 2 edges", a_flag2_n, 0);
    b_op(1, 1, 1, 2'b11, 36'h0_1111_2222);
    chk("R4 locked B write ignored", a_rdata, exp2);

    // R8 read without mailbox select, then R7 clear
    a_op(1, 1, 0, 0, '0);
    chk("R8 no clear without select", a_flag2_n, 0);
    a_op(1, 1, 0, 1, '0);
    chk("R7 a_flag2_n high", a_flag2_n, 1);
    chk("R8 mailbox2 after read", a_rdata, exp2);
    wait_b(1); chk("R7 b_flag2_n after 1 edge", b_flag2_n, 0);
    wait_b(1); chk("R7 b_flag2_n after 2 edges", b_flag2_n, 1);

    // round trips over varied data
    for (int k = 0; k < 8; k++) begin
      exp1 = (36'h1_2345_6789 * 36'(k + 3)) ^ (36'h1 << (k * 4));
      exp2 = ~exp1;
      a_op(1, 1, 1, 1, exp1);
      wait_b(2);
      peek1(got); chk("R2 round trip data", got, exp1);
      chk("R5 round trip flag", b_flag1_n, 0);
      b_op(1, 1, 0, 2'b11, '0);
      wait_a(2); chk("R6 round trip release", a_flag1_n, 1);
      b_op(1, 1, 1, 2'b11, exp2);
      wait_a(2);
      chk("R3 round trip data", a_rdata, exp2);
      chk("R5 round trip flag2", a_flag2_n, 0);
      a_op(1, 1, 0, 1, '0);
      wait_b(2); chk("R7 round trip release", b_flag2_n, 1);
    end

    // R10 asynchronous reset mid-operation
    a_op(1, 1, 1, 1, 36'h9_8765_4321);
    b_op(1, 1, 1, 2'b11, 36'h2_2222_3333);
    @(posedge clk_a); #1;
    rst_n = 1'b0;
    #0.1;
    chk("R10 a_flag1_n", a_flag1_n, 1);
    chk("R10 b_flag2_n", b_flag2_n, 1);
    chk("R10 a_rdata", a_rdata, '0);
    peek1(got); chk("R10 mailbox1", got, '0);
    #10;
    @(negedge clk_a); rst_n = 1'b1;
    wait_a(4); wait_b(4);
    chk("R1 flags after second reset", {a_flag1_n, a_flag2_n, b_flag1_n, b_flag2_n}, 4'hF);

    summary();
  end
endmodule